// File: doc/BRIEF.md
# Control Register Write Unit

This block holds the three translation and mode control registers of an x86-style processor core: the mode register (CR0), the table base register (CR3) and the feature-enable register (CR4). A single write port carries a register select and a data word. On each accepted write the block stores the new value, applies the architectural fix-ups, and refreshes a packed vector of hidden mode flags. The rest of the core reads these flags instead of decoding the registers again.

The block also watches for changes that make cached translations stale. When a write alters a translation-relevant bit, it raises a one-cycle flush request toward the TLB. That request appears in the same cycle as the register update.

A static capability vector states which optional CR4 enables the core implements. Enables that are not implemented are cleared before the value is stored. A two-bit view of the extended-state mask register feeds the AVX-enable flag.

The write port follows valid/ready rules, but the block never applies back-pressure: `wr_ready` is always high, and every cycle with `wr_valid` high is a completed write. Back-to-back writes are allowed. Each one is judged against the value left by the write before it.

Top module: `crw_ctrl_regs`

## Requirements
- R1: Select encoding is 0 for CR0, 1 for CR3 and 2 for CR4. A write with select 3 changes no register and no flag, and raises no flush. `wr_ready` is high in every cycle.
- R2: After reset, CR0 reads 0x10, and CR3, CR4, the hidden flags and the flush output read 0. A stored CR0 is the written value with bit 4 forced to 1.
- R3: A CR0 write raises a flush only if bit 31 (paging), bit 16 (write-protect) or bit 0 (protection-enable) differs from the stored value.
- R4: Hidden flag bit 0 copies CR0 bit 0 on every CR0 write. Hidden flag bit 1 (add segment base) is set by a CR0 write whose bit 0 is 0, and is left unchanged by a CR0 write whose bit 0 is 1.
- R5: Hidden flag bits 4:2 copy CR0 bits 3:1 as one group.
- R6: A CR3 write always stores the data. It raises a flush only while the stored CR0 bit 31 is 1.
- R7: A CR4 write raises a flush only if bit 4, 5, 7, 12, 20 or 21 of the masked new value differs from the stored CR4.
- R8: Before a CR4 value is stored, capability bits 0 to 5 gate CR4 bits 9, 21, 11, 22, 24 and 28 in that order. A CR4 bit whose capability bit is 0 is stored as 0.
- R9: A CR4 write recomputes hidden flag bits 5, 6 and 7 from the masked CR4 bits 9, 21 and 11. CR4 writes leave hidden flag bits 4:0 unchanged, and CR0 writes leave hidden flag bits 8:5 unchanged.
- R10: A CR4 write sets hidden flag bit 8 (AVX enable) only when the masked CR4 bit 18 is 1 and both bits of `xsave_state` are 1 in that cycle. Otherwise the write clears it.
- R11: The flush output is high only in the cycle that follows an accepted write that requires a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted (always high) |
| wr_sel | input | 2 | Register select: 0 CR0, 1 CR3, 2 CR4, 3 none |
| wr_data | input | DW | Write data |
| feat_caps | input | 6 | Optional CR4 enable capabilities |
| xsave_state | input | 2 | Extended-state mask bits {YMM, SSE} |
| cr0_o | output | DW | Stored CR0 |
| cr3_o | output | DW | Stored CR3 |
| cr4_o | output | DW | Stored CR4 |
| hflags_o | output | 9 | Packed hidden mode flags |
| flush_o | output | 1 | One-cycle TLB flush request |

## Verification
The hardest case to reach is a CR4 write that sets an unsupported enable bit while the stored value still holds that bit from a time when the capability was present. The masked value then toggles a translation bit even though the written data did not change it. The bench builds this in steps. It first sets SMAP and its neighbours with every capability present. It then removes the capabilities and rewrites the same bits. Finally it writes SMAP again with the capability still absent and expects no flush. This separates flush detection on the masked value from detection on the raw data.

// File: rtl/crw_pkg.sv
package crw_pkg;

  typedef enum logic [1:0] {
    SEL_MODE  = 2'd0,
    SEL_TBASE = 2'd1,
    SEL_FEAT  = 2'd2,
    SEL_NONE  = 2'd3
  } crw_sel_e;

  // mode register bit positions
  localparam int unsigned M_PE = 0;
  localparam int unsigned M_MP = 1;
  localparam int unsigned M_ET = 4;
  localparam int unsigned M_WP = 16;
  localparam int unsigned M_PG = 31;

  // feature register bit positions
  localparam int unsigned F_OSFXSR  = 9;
  localparam int unsigned F_UMIP    = 11;
  localparam int unsigned F_OSXSAVE = 18;
  localparam int unsigned F_SMAP    = 21;

  localparam int unsigned NUM_OPT   = 6;
  localparam int unsigned NUM_TRANS = 6;

  // hidden flag layout
  localparam int unsigned HF_PROT   = 0;
  localparam int unsigned HF_ADDSEG = 1;
  localparam int unsigned HF_FPU    = 2;
  localparam int unsigned HF_OSFXSR = 5;
  localparam int unsigned HF_SMAP   = 6;
  localparam int unsigned HF_UMIP   = 7;
  localparam int unsigned HF_AVX    = 8;
  localparam int unsigned HF_W      = 9;

  // capability index -> gated feature bit
  function automatic int unsigned opt_pos(int unsigned idx);
    case (idx)
      0: opt_pos = 9;
      1: opt_pos = 21;
      2: opt_pos = 11;
      3: opt_pos = 22;
      4: opt_pos = 24;
      default: opt_pos = 28;
    endcase
  endfunction

  // feature bits whose change invalidates translations
  function automatic int unsigned trans_pos(int unsigned idx);
    case (idx)
      0: trans_pos = 4;
      1: trans_pos = 5;
      2: trans_pos = 7;
      3: trans_pos = 12;
      4: trans_pos = 20;
      default: trans_pos = 21;
    endcase
  endfunction

endpackage

// File: rtl/crw_cr0_path.sv
module crw_cr0_path #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] cur,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] nxt,
  output logic          flush,
  output logic          pe,
  output logic [2:0]    fpu
);
  import crw_pkg::*;

  localparam logic [DW-1:0] ET_BIT = DW'(1) << M_ET;
  localparam logic [DW-1:0] WATCH  = (DW'(1) << M_PG) | (DW'(1) << M_WP) | (DW'(1) << M_PE);

  always_comb begin
    nxt   = wdata | ET_BIT;
    flush = |((nxt ^ cur) & WATCH);
    pe    = nxt[M_PE];
    fpu   = nxt[M_MP +: 3];
  end

endmodule

// File: rtl/crw_opt_mask.sv
module crw_opt_mask #(
  parameter int unsigned DW = 32
) (
  input  logic [crw_pkg::NUM_OPT-1:0] caps,
  output logic [DW-1:0]               keep
);
  import crw_pkg::*;

  logic [NUM_OPT-1:0][DW-1:0] clr;

  for (genvar g = 0; g < NUM_OPT; g++) begin : g_opt
    localparam int unsigned P = opt_pos(g);
    assign clr[g] = caps[g] ? '0 : (DW'(1) << P);
  end

  always_comb begin
    keep = '1;
    for (int i = 0; i < NUM_OPT; i++) keep = keep & ~clr[i];
  end

endmodule

// File: rtl/crw_cr4_path.sv
module crw_cr4_path #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0]               cur,
  input  logic [DW-1:0]               wdata,
  input  logic [crw_pkg::NUM_OPT-1:0] caps,
  input  logic [1:0]                  xsave_state,
  output logic [DW-1:0]               nxt,
  output logic                        flush,
  output logic                        osfxsr,
  output logic                        smap,
  output logic                        umip,
  output logic                        avx
);
  import crw_pkg::*;

  logic [DW-1:0] keep;
  logic [DW-1:0] watch;

  crw_opt_mask #(.DW(DW)) u_mask (
    .caps (caps),
    .keep (keep)
  );

  always_comb begin
    watch = '0;
    for (int i = 0; i < NUM_TRANS; i++) watch = watch | (DW'(1) << trans_pos(i));
  end

  always_comb begin
    nxt    = wdata & keep;
    flush  = |((nxt ^ cur) & watch);
    osfxsr = nxt[F_OSFXSR];
    smap   = nxt[F_SMAP];
    umip   = nxt[F_UMIP];
    avx    = nxt[F_OSXSAVE] & (&xsave_state);
  end

endmodule

// File: rtl/crw_ctrl_regs.sv
module crw_ctrl_regs #(
  parameter int unsigned DW = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_valid,
  output logic                        wr_ready,
  input  logic [1:0]                  wr_sel,
  input  logic [DW-1:0]               wr_data,
  input  logic [crw_pkg::NUM_OPT-1:0] feat_caps,
  input  logic [1:0]                  xsave_state,
  output logic [DW-1:0]               cr0_o,
  output logic [DW-1:0]               cr3_o,
  output logic [DW-1:0]               cr4_o,
  output logic [crw_pkg::HF_W-1:0]    hflags_o,
  output logic                        flush_o
);
  import crw_pkg::*;

  localparam logic [DW-1:0] MODE_RST = DW'(1) << M_ET;

  logic [DW-1:0]   mode_q, tbase_q, feat_q;
  logic [HF_W-1:0] hf_q;
  logic            flush_q;

  logic [DW-1:0] mode_nxt, feat_nxt;
  logic          mode_fl, feat_fl, pe_n, fx_n, smap_n, umip_n, avx_n;
  logic [2:0]    fpu_n;
  crw_sel_e      sel;

  assign sel      = crw_sel_e'(wr_sel);
  assign wr_ready = 1'b1;

  crw_cr0_path #(.DW(DW)) u_mode (
    .cur   (mode_q),
    .wdata (wr_data),
    .nxt   (mode_nxt),
    .flush (mode_fl),
    .pe    (pe_n),
    .fpu   (fpu_n)
  );

  crw_cr4_path #(.DW(DW)) u_feat (
    .cur         (feat_q),
    .wdata       (wr_data),
    .caps        (feat_caps),
    .xsave_state (xsave_state),
    .nxt         (feat_nxt),
    .flush       (feat_fl),
    .osfxsr      (fx_n),
    .smap        (smap_n),
    .umip        (umip_n),
    .avx         (avx_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MODE_RST;
      tbase_q <= '0;
      feat_q  <= '0;
      hf_q    <= '0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= 1'b0;
      if (wr_valid) begin
        case (sel)
          SEL_MODE: begin
            mode_q             <= mode_nxt;
            flush_q            <= mode_fl;
            hf_q[HF_PROT]      <= pe_n;
            hf_q[HF_FPU +: 3]  <= fpu_n;
            if (!pe_n) hf_q[HF_ADDSEG] <= 1'b1;
          end
          SEL_TBASE: begin
            tbase_q <= wr_data;
            flush_q <= mode_q[M_PG];
          end
          SEL_FEAT: begin
            feat_q            <= feat_nxt;
            flush_q           <= feat_fl;
            hf_q[HF_OSFXSR]   <= fx_n;
            hf_q[HF_SMAP]     <= smap_n;
            hf_q[HF_UMIP]     <= umip_n;
            hf_q[HF_AVX]      <= avx_n;
          end
          default: ;
        endcase
      end
    end
  end

  assign cr0_o    = mode_q;
  assign cr3_o    = tbase_q;
  assign cr4_o    = feat_q;
  assign hflags_o = hf_q;
  assign flush_o  = flush_q;

endmodule

// File: rtl/crw_checker.sv
module crw_checker #(
  parameter int unsigned DW = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_valid,
  input logic [1:0]                  wr_sel,
  input logic [DW-1:0]               wr_data,
  input logic [crw_pkg::NUM_OPT-1:0] feat_caps,
  input logic [1:0]                  xsave_state,
  input logic [DW-1:0]               cr0_o,
  input logic [DW-1:0]               cr3_o,
  input logic [DW-1:0]               cr4_o,
  input logic [crw_pkg::HF_W-1:0]    hflags_o,
  input logic                        flush_o
);
  import crw_pkg::*;

  localparam logic [DW-1:0] ETB   = DW'(1) << M_ET;
  localparam logic [DW-1:0] WATCH = (DW'(1) << M_PG) | (DW'(1) << M_WP) | (DW'(1) << M_PE);

  logic w_mode, w_tb, w_ft, w_none;
  assign w_mode = wr_valid && (wr_sel == 2'd0);
  assign w_tb   = wr_valid && (wr_sel == 2'd1);
  assign w_ft   = wr_valid && (wr_sel == 2'd2);
  assign w_none = wr_valid && (wr_sel == 2'd3);

  AST_IGNORE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    w_none |=> ($stable(cr0_o) && $stable(cr3_o) && $stable(cr4_o) && $stable(hflags_o) && !flush_o)); // R1
  AST_ET_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    w_mode |=> (cr0_o == ($past(wr_data) | ETB))); // R2
  AST_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (w_mode && (((wr_data ^ cr0_o) & WATCH) == '0)) |=> !flush_o); // R3
  AST_PROT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    w_mode |=> (hflags_o[HF_PROT] == cr0_o[M_PE])); // R4
  AST_ADDSEG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (w_mode && !wr_data[M_PE]) |=> hflags_o[HF_ADDSEG]); // R4
  AST_FPU_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    w_mode |=> (hflags_o[HF_FPU +: 3] == cr0_o[M_MP +: 3])); // R5
  AST_TBASE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (w_tb && cr0_o[M_PG]) |=> flush_o); // R6
  AST_TBASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (w_tb && !cr0_o[M_PG]) |=> !flush_o); // R6
  AST_CAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (w_ft && !feat_caps[1]) |=> !cr4_o[F_SMAP]); // R8
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    w_mode |=> (hflags_o[HF_AVX:HF_OSFXSR] == $past(hflags_o[HF_AVX:HF_OSFXSR]))); // R9
  AST_AVX_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    w_ft |=> (hflags_o[HF_AVX] == (cr4_o[F_OSXSAVE] && ($past(xsave_state) == 2'b11)))); // R10
  AST_NO_SPURIOUS_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> $past(wr_valid)); // R11

endmodule

bind crw_ctrl_regs crw_checker #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_valid    (wr_valid),
  .wr_sel      (wr_sel),
  .wr_data     (wr_data),
  .feat_caps   (feat_caps),
  .xsave_state (xsave_state),
  .cr0_o       (cr0_o),
  .cr3_o       (cr3_o),
  .cr4_o       (cr4_o),
  .hflags_o    (hflags_o),
  .flush_o     (flush_o)
);

// File: tb/tb_crw_ctrl_regs.sv
`timescale 1ns/1ps
module tb_crw_ctrl_regs;
  localparam int unsigned DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [1:0]    wr_sel = 2'd0;
  logic [DW-1:0] wr_data = '0;
  logic [5:0]    feat_caps = 6'h3F;
  logic [1:0]    xsave_state = 2'b11;
  logic [DW-1:0] cr0_o, cr3_o, cr4_o;
  logic [8:0]    hflags_o;
  logic          flush_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  crw_ctrl_regs #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data), .feat_caps(feat_caps),
    .xsave_state(xsave_state), .cr0_o(cr0_o), .cr3_o(cr3_o), .cr4_o(cr4_o),
    .hflags_o(hflags_o), .flush_o(flush_o)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one write, then return at the negedge where its result is visible
  task automatic wr(logic [1:0] s, logic [DW-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R2 reset cr0", cr0_o, 32'h10);
    chk("R2 reset cr3", cr3_o, 0);
    chk("R2 reset cr4", cr4_o, 0);
    chk("R2 reset hflags", hflags_o, 0);
    chk("R2 reset flush", flush_o, 0);
    chk("R1 ready", wr_ready, 1);
  endtask

  task automatic t_mode;
    wr(2'd0, 32'h1);
    chk("R2 et forced", cr0_o, 32'h11);
    chk("R3 pe change flush", flush_o, 1);
    chk("R4 prot flag", hflags_o, 9'h001);
    @(negedge clk);
    chk("R11 pulse ends", flush_o, 0);
    wr(2'd0, 32'hF);
    chk("R3 fpu only no flush", flush_o, 0);
    chk("R5 fpu copy", hflags_o, 9'h01D);
    wr(2'd0, 32'h0);
    chk("R3 pe clear flush", flush_o, 1);
    chk("R4 addseg set", hflags_o, 9'h002);
    wr(2'd0, 32'h1);
    chk("R4 addseg kept", hflags_o, 9'h003);
    wr(2'd0, 32'h0001_0001);
    chk("R3 wp flush", flush_o, 1);
    chk("R2 cr0 value", cr0_o, 32'h0001_0011);
  endtask

  task automatic t_tbase;
    wr(2'd1, 32'h1234_5000);
    chk("R6 cr3 stored", cr3_o, 32'h1234_5000);
    chk("R6 no flush pg off", flush_o, 0);
    wr(2'd0, 32'h8000_0001);
    chk("R3 pg flush", flush_o, 1);
    wr(2'd1, 32'hABCD_E000);
    chk("R6 flush pg on", flush_o, 1);
    chk("R6 cr3 stored 2", cr3_o, 32'hABCD_E000);
  endtask

  task automatic t_feat;
    feat_caps = 6'h3F; xsave_state = 2'b11;
    wr(2'd2, 32'h0024_0200);
    chk("R7 smap toggle flush", flush_o, 1);
    chk("R9 R10 flags", hflags_o, 9'h163);
    wr(2'd2, 32'h0024_0A00);
    chk("R7 umip no flush", flush_o, 0);
    chk("R9 umip flag", hflags_o, 9'h1E3);
    wr(2'd2, 32'h0064_0A00);
    chk("R7 pke no flush", flush_o, 0);
    chk("R8 pke kept", cr4_o, 32'h0064_0A00);
    wr(2'd0, 32'h8000_0001);
    chk("R3 same bits no flush", flush_o, 0);
    chk("R9 cr0 keeps cr4 flags", hflags_o, 9'h1E3);
  endtask

  task automatic t_caps;
    feat_caps = 6'h00;
    wr(2'd2, 32'h1164_0A00);
    chk("R8 optional bits cleared", cr4_o, 32'h0004_0000);
    chk("R7 masked smap drop flush", flush_o, 1);
    chk("R9 flags from masked", hflags_o, 9'h103);
    wr(2'd2, 32'h0024_0000);
    chk("R7 masked no toggle", flush_o, 0);
    chk("R8 smap stays clear", cr4_o, 32'h0004_0000);
    wr(2'd2, 32'h0004_0010);
    chk("R7 pse flush", flush_o, 1);
  endtask

  task automatic t_avx;
    feat_caps = 6'h3F; xsave_state = 2'b01;
    wr(2'd2, 32'h0004_0010);
    chk("R10 avx needs ymm", hflags_o, 9'h003);
    chk("R7 unchanged no flush", flush_o, 0);
  endtask

  task automatic t_ignored;
    wr(2'd3, 32'hFFFF_FFFF);
    chk("R1 cr0 untouched", cr0_o, 32'h8000_0011);
    chk("R1 cr3 untouched", cr3_o, 32'hABCD_E000);
    chk("R1 cr4 untouched", cr4_o, 32'h0004_0010);
    chk("R1 flags untouched", hflags_o, 9'h003);
    chk("R1 no flush", flush_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode();
    t_tbase();
    t_feat();
    t_caps();
    t_avx();
    t_ignored();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule